// File: doc/BRIEF.md
# Crossing-Grouped Hit Packetizer

The packetizer accepts a time-ordered stream of pixel hits over a valid/ready handshake. Each hit carries a chip id, a bunch-crossing number, a 12-bit pixel address and a 3-bit amplitude. The block groups consecutive hits that share both crossing number and chip id into one packet. A packet is built from 16-bit words: one header, then one data word per hit. These 16-bit words are packed two at a time into 32-bit output words, which leave on a stream with a last flag.

A packet closes when a hit arrives with a different crossing number or chip id, or when the flush input is raised. When the packet's count of 16-bit words is odd, a zero half-word is added so that the packet ends on a whole 32-bit word. The last flag marks the final 32-bit word of each packet. The newest complete word is held back until the block knows whether it is the final word of its packet.

Top module: `hit_packetizer`

## Requirements
- R1: A header half-word is {bit 15:14 = 2'b10, bit 13 = 0, bits 12:8 = chip id, bits 7:0 = crossing number}.
- R2: A data half-word is {bit 15 = 0, bits 14:3 = pixel address, bits 2:0 = amplitude}.
- R3: Within a packet, half-words fill each 32-bit word upper half (31:16) first, then lower half (15:0). The first word carries the header in the upper half and the first hit in the lower half. Consecutive hits with the same chip id and crossing number extend the open packet.
- R4: A hit whose crossing number differs from the open packet's closes that packet and starts a new one with its own header.
- R5: A hit whose chip id differs from the open packet's closes that packet and starts a new one.
- R6: The final 32-bit word of every packet has out_last = 1, and every other word has out_last = 0. When the packet's 16-bit count (header plus hits) is odd, the lower half of its final word is 16'h0000.
- R7: flush, taken in a cycle with hit_ready = 1, closes the open packet. If a hit is accepted in the same cycle, that hit starts a new packet, which stays open. A flush with no packet open produces no output word.
- R8: While out_valid = 1 and out_ready = 0, out_data and out_last hold their values and hit_ready = 0. Otherwise hit_ready = 1.
- R9: After reset, out_valid = 0 and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit (and flush) taken this cycle |
| hit_chip | input | CHIP_W | Chip id of the hit |
| hit_xing | input | XING_W | Crossing number of the hit |
| hit_addr | input | ADDR_W | Pixel address |
| hit_amp | input | AMP_W | Amplitude |
| flush | input | 1 | Close the open packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink takes output word |
| out_data | output | 32 | Packed output word |
| out_last | output | 1 | Final word of a packet |

## Verification
The bench builds the block with its default widths: a 5-bit chip id, an 8-bit crossing number, a 12-bit address and a 3-bit amplitude. These widths make the header and data half-words exactly 16 bits, so every field position in R1 and R2 can be checked bit for bit. The random phase draws crossing numbers from a small range. This produces many short packets, repeated crossing values across packet boundaries, and both pad and no-pad endings, all while the sink stalls at random.

// File: rtl/hit_packetizer.sv
module hit_packetizer #(
  parameter int CHIP_W = 5,
  parameter int XING_W = 8,
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [CHIP_W-1:0] hit_chip,
  input  logic [XING_W-1:0] hit_xing,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [AMP_W-1:0]  hit_amp,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_last
);
  localparam int HALF_W = 3 + CHIP_W + XING_W;

  logic              open_q, full_q, first_q;
  logic [CHIP_W-1:0] chip_q;
  logic [XING_W-1:0] xing_q;
  logic [31:0]       acc_q;

  wire [HALF_W-1:0] hdr_w  = {2'b10, 1'b0, hit_chip, hit_xing};
  wire [HALF_W-1:0] data_w = {1'b0, hit_addr, hit_amp};

  assign hit_ready = !out_valid || out_ready;

  wire take    = hit_ready && hit_valid;
  wire act     = hit_ready && flush;
  wire keydiff = (hit_chip != chip_q) || (hit_xing != xing_q);
  wire start   = take && (act || !open_q || keydiff);
  wire close   = open_q && (act || (take && keydiff));
  wire mid     = take && !start && full_q;
  wire emit    = close || mid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (hit_ready) begin
      out_valid <= emit;
      if (emit) begin
        out_data <= acc_q;
        out_last <= close;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      full_q <= 1'b0;
      chip_q <= '0;
      xing_q <= '0;
      acc_q  <= '0;
    end else if (start) begin
      open_q <= 1'b1;
      full_q <= 1'b1;
      chip_q <= hit_chip;
      xing_q <= hit_xing;
      acc_q  <= {hdr_w, data_w};
    end else begin
      if (act) open_q <= 1'b0;
      if (take) begin
        if (full_q) begin
          acc_q  <= {data_w, 16'h0000};
          full_q <= 1'b0;
        end else begin
          acc_q[15:0] <= data_w;
          full_q      <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) first_q <= 1'b1;
    else if (out_valid && out_ready) first_q <= out_last;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !hit_ready);

  // R1
  head_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && first_q |-> out_data[31:29] == 3'b100);

  // R2
  body_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !first_q |-> !out_data[31]);

  // R2
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_data[15]);

  // R7
  flush_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && hit_ready && !hit_valid |=> !open_q);
endmodule

// File: tb/test_hit_packetizer.sv
module test_hit_packetizer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hit_valid = 1'b0, flush = 1'b0, out_ready = 1'b1;
  logic [4:0] hit_chip = '0;
  logic [7:0] hit_xing = '0;
  logic [11:0] hit_addr = '0;
  logic [2:0] hit_amp = '0;
  logic hit_ready, out_valid, out_last;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  hit_packetizer i_hit_packetizer (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_chip(hit_chip), .hit_xing(hit_xing), .hit_addr(hit_addr), .hit_amp(hit_amp),
    .flush(flush), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  int checks = 0, fails = 0;
  logic [32:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R3";
  bit bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  bit m_open = 0, m_full = 0;
  logic [4:0] m_chip;
  logic [7:0] m_xing;
  logic [31:0] m_acc;

  task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input bit last, input logic [31:0] w, input string tag);
    exp_q.push_back({last, w});
    tag_q.push_back(tag);
  endtask

  task automatic model_hit(input logic [4:0] c, input logic [7:0] x, input logic [11:0] a,
                           input logic [2:0] p, input bit f);
    logic [15:0] h, d;
    bit st, kd;
    h = {2'b10, 1'b0, c, x};
    d = {1'b0, a, p};
    kd = (c != m_chip) || (x != m_xing);
    st = f || !m_open || kd;
    if (m_open && st)
      push(1'b1, m_acc, f ? "R7" : ((c != m_chip) ? "R5" : "R4"));
    else if (!st && m_full)
      push(1'b0, m_acc, cur_tag);
    if (st) begin
      m_acc = {h, d}; m_full = 1; m_open = 1; m_chip = c; m_xing = x;
    end else if (m_full) begin
      m_acc = {d, 16'h0000}; m_full = 0;
    end else begin
      m_acc[15:0] = d; m_full = 1;
    end
  endtask

  task automatic send(input logic [4:0] c, input logic [7:0] x, input logic [11:0] a,
                      input logic [2:0] p, input bit f);
    @(posedge clk); #2;
    hit_valid = 1'b1; hit_chip = c; hit_xing = x; hit_addr = a; hit_amp = p; flush = f;
    do @(negedge clk); while (!hit_ready);
    model_hit(c, x, a, p, f);
    @(posedge clk); #2;
    hit_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #2;
    flush = 1'b1;
    do @(negedge clk); while (!hit_ready);
    if (m_open) push(1'b1, m_acc, "R7");
    m_open = 0;
    @(posedge clk); #2;
    flush = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp ? lfsr[0] : 1'b1;
  end

  bit pv = 0;
  logic [32:0] pw;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv) check(out_valid && {out_last, out_data} == pw, "R8 hold",
                    {out_last, out_data}, pw);
      if (out_valid && !out_ready) check(!hit_ready, "R8 ready", {32'b0, hit_ready}, 33'b0);
      pv = out_valid && !out_ready;
      pw = {out_last, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", {out_last, out_data}, 33'b0);
        else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_last, out_data} == e, t, {out_last, out_data}, e);
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && hit_ready, "R9 reset", {31'b0, out_valid, hit_ready}, 33'b1);
    rst_n = 1'b1;

    // R1 R2 R6: one hit, no pad, literal expectation
    cur_tag = "R1 R2 R3";
    send(5'h15, 8'hA7, 12'hABC, 3'd5, 0);
    do_flush();
    repeat (4) @(posedge clk);
    // R7: flush with nothing open emits nothing
    do_flush();
    repeat (4) @(negedge clk);
    check(!out_valid && exp_q.size() == 0, "R7 idle flush", {32'b0, out_valid}, 33'b0);

    // R6 pad: two hits
    cur_tag = "R6";
    send(5'h01, 8'h10, 12'h001, 3'd1, 0);
    send(5'h01, 8'h10, 12'hFFF, 3'd7, 0);
    do_flush();
    // R3 three hits, no pad
    cur_tag = "R3";
    send(5'h02, 8'h11, 12'h123, 3'd2, 0);
    send(5'h02, 8'h11, 12'h456, 3'd3, 0);
    send(5'h02, 8'h11, 12'h789, 3'd4, 0);
    // R4 crossing change, R5 chip change
    send(5'h02, 8'h12, 12'h0AA, 3'd0, 0);
    send(5'h03, 8'h12, 12'h0BB, 3'd6, 0);
    // R7 flush with simultaneous hit
    send(5'h03, 8'h12, 12'h0CC, 3'd1, 1);
    do_flush();
    repeat (6) @(posedge clk);

    // R8 random stream under backpressure
    bp = 1'b1;
    cur_tag = "R3 R8";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] x;
      logic [4:0] c;
      x = 8'($urandom_range(0, 3));
      c = 5'($urandom_range(0, 1));
      send(c, x, 12'($urandom), 3'($urandom), ($urandom_range(0, 19) == 0));
    end
    do_flush();
    bp = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R6 drained", 33'(exp_q.size()), 33'b0);
    summary();
  end
endmodule